// File: doc/BRIEF.md
# IDE Channel Address Decoder and Router

This block sits between the host programmed-I/O path and the drive-side register logic of a two-channel disk controller. Each host access is compared against five programmable windows: a command window and a control window for each of the two channels, and one shared window for the bus-master registers. One cycle later the block reports which window matched, which channel the access belongs to, the byte offset inside the window, and which of four attached drives the access is routed to.

The drive index combines the channel with a per-channel drive-select bit. The block snoops that bit from host writes to the select register in the command window. Accesses are gated by the I/O-enable and bus-master-enable bits of the PCI command register. Each access ends in exactly one of three outcomes: forwarded, dropped by the enable gating, or flagged as an error. Errors cover an address outside all windows and an access size that is not allowed. Window bases are loaded through a small configuration port, one window at a time.

Top module: `ide_route_dec`

## Requirements
- R1: After reset all five window bases are zero, both enables are off, both drive-select bits are 0 and `rsp_valid_o` is low.
- R2: An access presented with `acc_valid_i` high gives `rsp_valid_o` high on the next cycle. For a matching window, `rsp_off_o` is the address minus that window's base. `rsp_kind_o` is 0 for a command window, 1 for a control window and 2 for the bus-master window.
- R3: When windows overlap, the first match wins in this order: primary command (index 0), primary control (1), secondary command (2), secondary control (3), bus-master (4).
- R4: In the bus-master window, offsets below `BM_SPLIT` (default 8) report `rsp_sec_o`=0 and all other offsets report `rsp_sec_o`=1.
- R5: A forwarded write to command-window offset `SEL_OFF` (default 6) stores bit `SEL_BIT` (default 4) of `acc_wdata_i` as that channel's drive-select bit. The bits of the two channels are independent, and writes to other offsets leave them unchanged.
- R6: `rsp_drive_o` equals the channel's drive-select bit plus 2 when `rsp_sec_o`=1.
- R7: A write that changes the drive-select bit is routed using the new bit value in that same response.
- R8: With I/O enable (command bit 0) clear, every access that hits a window is dropped, and a dropped write does not change a drive-select bit. With bus-master enable (command bit 2) clear, writes to the bus-master window are dropped and reads of it are forwarded.
- R9: An access with a size other than 1, 2 or 4 bytes is an error. A 4-byte access to a command or control window is an error. A 4-byte access to the bus-master window is forwarded.
- R10: An address matching no window gives `rsp_err_o`=1 and `rsp_kind_o`=3, whatever the enables are.
- R11: A base write with value zero, or with a window index above 4, leaves every base unchanged. A nonzero write moves the selected window to the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_bar_we_i | input | 1 | Load a window base |
| cfg_bar_idx_i | input | 3 | Window index 0..4 (priority order) |
| cfg_bar_val_i | input | ADDR_W | New base value |
| cfg_cmd_we_i | input | 1 | Load the PCI command bits |
| cfg_cmd_val_i | input | 16 | Command value; bit 0 I/O enable, bit 2 bus-master enable |
| acc_valid_i | input | 1 | Host access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Access address |
| acc_size_i | input | 3 | Access size in bytes |
| acc_wdata_i | input | 8 | Low byte of write data |
| rsp_valid_o | output | 1 | Decode result valid |
| rsp_fwd_o | output | 1 | Access forwarded |
| rsp_drop_o | output | 1 | Access dropped by enable gating |
| rsp_err_o | output | 1 | Address miss or illegal size |
| rsp_write_o | output | 1 | Direction of the decoded access |
| rsp_kind_o | output | 2 | 0 command, 1 control, 2 bus-master, 3 none |
| rsp_sec_o | output | 1 | Channel: 0 primary, 1 secondary |
| rsp_off_o | output | OFF_W | Offset inside the window |
| rsp_drive_o | output | 2 | Target drive index 0..3 |

## Verification
The bench first decodes with every base still at zero, where all windows overlap at address 0. This shows that the priority order, and not the base values, decides the window. With the bases spread apart, an address in each window checks the offset subtraction and the kind and channel coding. Addresses on both sides of the bus-master split point separate the two channels inside that window. Select-register writes with bit 4 set and clear, writes to the neighbouring offset, and writes made while I/O is disabled show that the drive index follows only the forwarded select writes, and that each channel keeps its own bit. Size sweeps and moved or zero base loads separate the error outcome from the drop outcome, and the old window location from the new one.

// File: rtl/ide_route_pkg.sv
package ide_route_pkg;
  typedef enum logic [1:0] {
    WK_CMD  = 2'd0,
    WK_CTRL = 2'd1,
    WK_BM   = 2'd2,
    WK_NONE = 2'd3
  } win_kind_e;

  localparam int NWIN = 5;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int ADDR_W = 16,
  parameter int SIZE   = 8,
  parameter int OFF_W  = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam logic [ADDR_W:0] SIZE_V = (ADDR_W+1)'(SIZE);

  logic [ADDR_W:0] diff;

  // extra bit catches addr below base
  assign diff  = {1'b0, addr_i} - {1'b0, base_i};
  assign hit_o = !diff[ADDR_W] && (diff < SIZE_V);
  assign off_o = diff[OFF_W-1:0];
endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs #(
  parameter int ADDR_W = 16,
  parameter int NWIN   = 5,
  parameter int IO_BIT = 0,
  parameter int BM_BIT = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bar_we_i,
  input  logic [2:0]                   bar_idx_i,
  input  logic [ADDR_W-1:0]            bar_val_i,
  input  logic                         cmd_we_i,
  input  logic [15:0]                  cmd_val_i,
  output logic [NWIN-1:0][ADDR_W-1:0]  base_o,
  output logic                         io_en_o,
  output logic                         bm_en_o
);
  for (genvar i = 0; i < NWIN; i++) begin : g_bar
    logic ld;
    assign ld = bar_we_i && (bar_idx_i == 3'(i)) && (bar_val_i != '0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  base_o[i] <= '0;
      else if (ld)  base_o[i] <= bar_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_en_o <= 1'b0;
      bm_en_o <= 1'b0;
    end else if (cmd_we_i) begin
      io_en_o <= cmd_val_i[IO_BIT];
      bm_en_o <= cmd_val_i[BM_BIT];
    end
  end
endmodule

// File: rtl/ide_dev_shadow.sv
module ide_dev_shadow (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic       chan_i,
  input  logic       val_i,
  output logic [1:0] dev_o
);
  for (genvar c = 0; c < 2; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           dev_o[c] <= 1'b0;
      else if (upd_i && (chan_i == 1'(c)))   dev_o[c] <= val_i;
    end
  end
endmodule

// File: rtl/ide_route_dec.sv
module ide_route_dec
  import ide_route_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CMD_SZ   = 8,
  parameter int CTRL_SZ  = 4,
  parameter int BM_SZ    = 16,
  parameter int BM_SPLIT = 8,
  parameter int SEL_OFF  = 6,
  parameter int SEL_BIT  = 4,
  parameter int IO_BIT   = 0,
  parameter int BM_BIT   = 2,
  localparam int MAX_SZ  = max3(CMD_SZ, CTRL_SZ, BM_SZ),
  localparam int OFF_W   = (MAX_SZ > 1) ? $clog2(MAX_SZ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_bar_we_i,
  input  logic [2:0]        cfg_bar_idx_i,
  input  logic [ADDR_W-1:0] cfg_bar_val_i,
  input  logic              cfg_cmd_we_i,
  input  logic [15:0]       cfg_cmd_val_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [2:0]        acc_size_i,
  input  logic [7:0]        acc_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_fwd_o,
  output logic              rsp_drop_o,
  output logic              rsp_err_o,
  output logic              rsp_write_o,
  output logic [1:0]        rsp_kind_o,
  output logic              rsp_sec_o,
  output logic [OFF_W-1:0]  rsp_off_o,
  output logic [1:0]        rsp_drive_o
);
  logic [NWIN-1:0][ADDR_W-1:0] base;
  logic                        io_en, bm_en;
  logic [NWIN-1:0]             hit;
  logic [NWIN-1:0][OFF_W-1:0]  offs;
  logic [1:0]                  dev;

  ide_cfg_regs #(
    .ADDR_W(ADDR_W), .NWIN(NWIN), .IO_BIT(IO_BIT), .BM_BIT(BM_BIT)
  ) u_cfg (
    .clk_i, .rst_ni,
    .bar_we_i (cfg_bar_we_i),
    .bar_idx_i(cfg_bar_idx_i),
    .bar_val_i(cfg_bar_val_i),
    .cmd_we_i (cfg_cmd_we_i),
    .cmd_val_i(cfg_cmd_val_i),
    .base_o   (base),
    .io_en_o  (io_en),
    .bm_en_o  (bm_en)
  );

  // window i: even = command, odd = control, last = bus-master
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam int SZ = (i == NWIN-1) ? BM_SZ : ((i % 2) == 0 ? CMD_SZ : CTRL_SZ);
    ide_win_match #(.ADDR_W(ADDR_W), .SIZE(SZ), .OFF_W(OFF_W)) u_m (
      .base_i(base[i]),
      .addr_i(acc_addr_i),
      .hit_o (hit[i]),
      .off_o (offs[i])
    );
  end

  logic [2:0]       win_idx;
  logic             miss;
  win_kind_e        kind;
  logic             sec;
  logic [OFF_W-1:0] off;

  always_comb begin
    win_idx = 3'd7;
    for (int i = NWIN-1; i >= 0; i--)
      if (hit[i]) win_idx = 3'(i);
  end

  always_comb begin
    miss = 1'b0;
    kind = WK_NONE;
    sec  = 1'b0;
    off  = '0;
    case (win_idx)
      3'd0: begin kind = WK_CMD;  sec = 1'b0; off = offs[0]; end
      3'd1: begin kind = WK_CTRL; sec = 1'b0; off = offs[1]; end
      3'd2: begin kind = WK_CMD;  sec = 1'b1; off = offs[2]; end
      3'd3: begin kind = WK_CTRL; sec = 1'b1; off = offs[3]; end
      3'd4: begin
        kind = WK_BM;
        off  = offs[4];
        sec  = (offs[4] >= OFF_W'(BM_SPLIT));
      end
      default: miss = 1'b1;
    endcase
  end

  logic size_ok, dword_bad, gated, fwd, drop, err, sel_wr, dev_now;
  logic [1:0] drive;

  always_comb begin
    size_ok   = (acc_size_i == 3'd1) || (acc_size_i == 3'd2) || (acc_size_i == 3'd4);
    dword_bad = (acc_size_i == 3'd4) && (kind != WK_BM);
    gated     = !io_en || (acc_write_i && (kind == WK_BM) && !bm_en);
    fwd       = !miss && !gated && size_ok && !dword_bad;
    drop      = !miss && gated;
    err       = miss || (!gated && (!size_ok || dword_bad));
    sel_wr    = acc_valid_i && fwd && acc_write_i && (kind == WK_CMD) &&
                (off == OFF_W'(SEL_OFF));
    dev_now   = sel_wr ? acc_wdata_i[SEL_BIT] : dev[sec];
    drive     = miss ? 2'd0 : {sec, dev_now};
  end

  ide_dev_shadow u_dev (
    .clk_i, .rst_ni,
    .upd_i (sel_wr),
    .chan_i(sec),
    .val_i (acc_wdata_i[SEL_BIT]),
    .dev_o (dev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fwd_o   <= 1'b0;
      rsp_drop_o  <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_write_o <= 1'b0;
      rsp_kind_o  <= WK_NONE;
      rsp_sec_o   <= 1'b0;
      rsp_off_o   <= '0;
      rsp_drive_o <= '0;
    end else begin
      rsp_valid_o <= acc_valid_i;
      rsp_fwd_o   <= acc_valid_i && fwd;
      rsp_drop_o  <= acc_valid_i && drop;
      rsp_err_o   <= acc_valid_i && err;
      rsp_write_o <= acc_write_i;
      rsp_kind_o  <= kind;
      rsp_sec_o   <= sec;
      rsp_off_o   <= off;
      rsp_drive_o <= drive;
    end
  end
endmodule

// File: rtl/ide_route_chk.sv
module ide_route_chk #(
  parameter int OFF_W    = 4,
  parameter int BM_SPLIT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             io_en_i,
  input logic             rsp_valid_o,
  input logic             rsp_fwd_o,
  input logic             rsp_drop_o,
  input logic             rsp_err_o,
  input logic [1:0]       rsp_kind_o,
  input logic             rsp_sec_o,
  input logic [OFF_W-1:0] rsp_off_o,
  input logic [1:0]       rsp_drive_o
);
  // R2 one-cycle response
  a_r2_resp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> rsp_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !rsp_valid_o);
  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $onehot({rsp_fwd_o, rsp_drop_o, rsp_err_o}));
  // R10 miss is an error
  a_r10_miss_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd3) |-> rsp_err_o);
  // R8 I/O gating never forwards
  a_r8_io_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !io_en_i) |=> !rsp_fwd_o);
  // R6 drive high bit is the channel
  a_r6_drive_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o != 2'd3) |-> (rsp_drive_o[1] == rsp_sec_o));
  // R4 bus-master channel split
  a_r4_bm_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd2) |->
      (rsp_sec_o == (rsp_off_o >= OFF_W'(BM_SPLIT))));
endmodule

bind ide_route_dec ide_route_chk #(.OFF_W(OFF_W), .BM_SPLIT(BM_SPLIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_valid_i(acc_valid_i),
  .io_en_i    (io_en),
  .rsp_valid_o(rsp_valid_o),
  .rsp_fwd_o  (rsp_fwd_o),
  .rsp_drop_o (rsp_drop_o),
  .rsp_err_o  (rsp_err_o),
  .rsp_kind_o (rsp_kind_o),
  .rsp_sec_o  (rsp_sec_o),
  .rsp_off_o  (rsp_off_o),
  .rsp_drive_o(rsp_drive_o)
);

// File: tb/ide_route_dec_tb.sv
`timescale 1ns/1ps
module ide_route_dec_tb;
  localparam int AW = 16;
  localparam logic [2:0] O_FWD = 3'b001, O_DROP = 3'b010, O_ERR = 3'b100;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_bar_we_i = 1'b0;
  logic [2:0]    cfg_bar_idx_i = '0;
  logic [AW-1:0] cfg_bar_val_i = '0;
  logic          cfg_cmd_we_i = 1'b0;
  logic [15:0]   cfg_cmd_val_i = '0;
  logic          acc_valid_i = 1'b0;
  logic          acc_write_i = 1'b0;
  logic [AW-1:0] acc_addr_i = '0;
  logic [2:0]    acc_size_i = 3'd1;
  logic [7:0]    acc_wdata_i = '0;
  logic          rsp_valid_o, rsp_fwd_o, rsp_drop_o, rsp_err_o, rsp_write_o, rsp_sec_o;
  logic [1:0]    rsp_kind_o, rsp_drive_o;
  logic [3:0]    rsp_off_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ide_route_dec u_dut (
    .clk_i(clk), .rst_ni,
    .cfg_bar_we_i, .cfg_bar_idx_i, .cfg_bar_val_i,
    .cfg_cmd_we_i, .cfg_cmd_val_i,
    .acc_valid_i, .acc_write_i, .acc_addr_i, .acc_size_i, .acc_wdata_i,
    .rsp_valid_o, .rsp_fwd_o, .rsp_drop_o, .rsp_err_o, .rsp_write_o,
    .rsp_kind_o, .rsp_sec_o, .rsp_off_o, .rsp_drive_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bar_wr(input int idx, input int val);
    @(negedge clk);
    cfg_bar_we_i = 1'b1; cfg_bar_idx_i = 3'(idx); cfg_bar_val_i = AW'(val);
    @(negedge clk);
    cfg_bar_we_i = 1'b0;
  endtask

  task automatic cmd_wr(input int val);
    @(negedge clk);
    cfg_cmd_we_i = 1'b1; cfg_cmd_val_i = 16'(val);
    @(negedge clk);
    cfg_cmd_we_i = 1'b0;
  endtask

  // drive one access, sample the response one edge later
  task automatic acc(input string tag, input bit wr, input int addr, input int size,
                     input int wd, input logic [2:0] exp_o, input int ek,
                     input int es, input int eoff, input int ed);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_write_i = wr; acc_addr_i = AW'(addr);
    acc_size_i = 3'(size); acc_wdata_i = 8'(wd);
    @(negedge clk);
    acc_valid_i = 1'b0;
    chk({tag, " valid"}, int'(rsp_valid_o), 1);
    chk({tag, " outcome"}, int'({rsp_err_o, rsp_drop_o, rsp_fwd_o}), int'(exp_o));
    chk({tag, " kind"}, int'(rsp_kind_o), ek);
    if (ek != 3) begin
      chk({tag, " sec"}, int'(rsp_sec_o), es);
      chk({tag, " off"}, int'(rsp_off_o), eoff);
      chk({tag, " drive"}, int'(rsp_drive_o), ed);
    end
  endtask

  task automatic t_reset();
    chk("R1 valid low after reset", int'(rsp_valid_o), 0);
    // all bases zero: every window covers 0, primary command wins (R1, R3); io off drops (R8)
    acc("R1 R3 zero bases", 1'b0, 3, 1, 0, O_DROP, 0, 0, 3, 0);
    acc("R10 miss at reset", 1'b0, 16'h10, 1, 0, O_ERR, 3, 0, 0, 0);
  endtask

  task automatic t_program();
    cmd_wr(16'h0005);
    bar_wr(0, 16'h100); bar_wr(1, 16'h200); bar_wr(2, 16'h300);
    bar_wr(3, 16'h400); bar_wr(4, 16'h500);
  endtask

  task automatic t_decode();
    acc("R2 pri ctrl", 1'b0, 16'h203, 1, 0, O_FWD, 1, 0, 3, 0);
    acc("R2 sec cmd", 1'b0, 16'h305, 2, 0, O_FWD, 0, 1, 5, 2);
    acc("R2 sec ctrl", 1'b0, 16'h402, 1, 0, O_FWD, 1, 1, 2, 2);
    acc("R2 pri cmd", 1'b1, 16'h101, 2, 0, O_FWD, 0, 0, 1, 0);
    acc("R10 gap miss", 1'b0, 16'h108, 1, 0, O_ERR, 3, 0, 0, 0);
  endtask

  task automatic t_bm_split();
    acc("R4 bm below split", 1'b0, 16'h507, 1, 0, O_FWD, 2, 0, 7, 0);
    acc("R4 bm at split", 1'b0, 16'h508, 1, 0, O_FWD, 2, 1, 8, 2);
    acc("R4 bm top", 1'b1, 16'h50f, 1, 0, O_FWD, 2, 1, 15, 2);
  endtask

  task automatic t_select();
    acc("R7 sec select set", 1'b1, 16'h306, 1, 16'h10, O_FWD, 0, 1, 6, 3);
    acc("R6 sec follows", 1'b0, 16'h300, 1, 0, O_FWD, 0, 1, 0, 3);
    acc("R5 pri independent", 1'b0, 16'h100, 1, 0, O_FWD, 0, 0, 0, 0);
    acc("R7 pri select clr", 1'b1, 16'h106, 1, 16'hef, O_FWD, 0, 0, 6, 0);
    acc("R7 pri select set", 1'b1, 16'h106, 1, 16'h10, O_FWD, 0, 0, 6, 1);
    acc("R6 pri follows", 1'b0, 16'h101, 1, 0, O_FWD, 0, 0, 1, 1);
    acc("R6 sec ctrl", 1'b0, 16'h401, 1, 0, O_FWD, 1, 1, 1, 3);
    acc("R5 sec select clr", 1'b1, 16'h306, 1, 16'h00, O_FWD, 0, 1, 6, 2);
    acc("R5 other offset", 1'b1, 16'h307, 1, 16'h10, O_FWD, 0, 1, 7, 2);
    acc("R5 bit kept", 1'b0, 16'h300, 1, 0, O_FWD, 0, 1, 0, 2);
  endtask

  task automatic t_size();
    acc("R9 dword cmd", 1'b0, 16'h100, 4, 0, O_ERR, 0, 0, 0, 1);
    acc("R9 dword ctrl", 1'b0, 16'h200, 4, 0, O_ERR, 1, 0, 0, 1);
    acc("R9 size 3", 1'b0, 16'h300, 3, 0, O_ERR, 0, 1, 0, 2);
    acc("R9 size 0", 1'b1, 16'h500, 0, 0, O_ERR, 2, 0, 0, 1);
    acc("R9 dword bm", 1'b1, 16'h504, 4, 0, O_FWD, 2, 0, 4, 1);
  endtask

  task automatic t_gate();
    cmd_wr(16'h0001);
    acc("R8 bm write dropped", 1'b1, 16'h500, 1, 0, O_DROP, 2, 0, 0, 1);
    acc("R8 bm read fwd", 1'b0, 16'h509, 1, 0, O_FWD, 2, 1, 9, 2);
    acc("R8 cmd write fwd", 1'b1, 16'h102, 1, 0, O_FWD, 0, 0, 2, 1);
    cmd_wr(16'h0004);
    acc("R8 io off read", 1'b0, 16'h100, 1, 0, O_DROP, 0, 0, 0, 1);
    acc("R8 io off select", 1'b1, 16'h106, 1, 0, O_DROP, 0, 0, 6, 1);
    acc("R10 miss io off", 1'b0, 16'h900, 1, 0, O_ERR, 3, 0, 0, 0);
    cmd_wr(16'h0005);
    acc("R8 dropped select ignored", 1'b0, 16'h100, 1, 0, O_FWD, 0, 0, 0, 1);
  endtask

  task automatic t_bar();
    bar_wr(1, 0);
    acc("R11 zero base ignored", 1'b0, 16'h201, 1, 0, O_FWD, 1, 0, 1, 1);
    bar_wr(5, 16'h700);
    acc("R11 idx 5 ignored", 1'b0, 16'h700, 1, 0, O_ERR, 3, 0, 0, 0);
    bar_wr(1, 16'h600);
    acc("R11 moved new", 1'b0, 16'h602, 1, 0, O_FWD, 1, 0, 2, 1);
    acc("R11 moved old", 1'b0, 16'h200, 1, 0, O_ERR, 3, 0, 0, 0);
    bar_wr(2, 16'h104);
    acc("R3 pri cmd wins", 1'b0, 16'h105, 1, 0, O_FWD, 0, 0, 5, 1);
    acc("R3 sec tail", 1'b0, 16'h109, 1, 0, O_FWD, 0, 1, 5, 2);
    bar_wr(4, 16'h600);
    acc("R3 ctrl over bm", 1'b0, 16'h601, 1, 0, O_FWD, 1, 0, 1, 1);
    acc("R3 bm past ctrl", 1'b0, 16'h604, 1, 0, O_FWD, 2, 0, 4, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_decode();
    t_bm_split();
    t_select();
    t_size();
    t_gate();
    t_bar();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule